// File: doc/BRIEF.md
# Two-Field Circular Channel Buffer Address Generator

This block turns word requests from fifteen I/O channels into addresses in one shared word memory. Every channel owns two buffer regions, one for data arriving from the channel and one for data leaving toward it. Each region is a ring of `2**OFF_W` words laid out back to back above `BASE_ADDR`. The ring is split into a lower field and an upper field. A word pointer walks the ring, running from the lower field into the upper field and then back to the start of the lower field.

A single memory port is shared among the thirty requesters by a fixed-priority arbiter. When the pointer leaves a field, the block raises a pending interrupt for that region and records which field was just finished. The channel carries on in the other field at once. Software reads the finished field and then clears the pending bit through a clear input.

The memory side offers one access at a time. A stall input stretches the access for as long as the memory reports a bank conflict. After every completed access there is one idle cycle, which limits throughput to one word every two clocks.

Top module: `chan_ring_addr`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after its release, `mem_valid_o`, all ack bits and all interrupt pending bits are 0. Every region pointer starts at offset 0.
- R2: During an access for channel c (1..15) and direction d (0 = incoming, 1 = outgoing), `mem_addr_o` equals `BASE_ADDR + (2*(c-1)+d)*2**OFF_W + offset`. In the same access `mem_we_o` equals 1 exactly when d = 0, and `chan_o` equals c.
- R3: When several requests are pending, the grant goes to the lowest channel number. Within one channel, incoming wins over outgoing.
- R4: An access completes in a cycle where `mem_valid_o` is 1 and `mem_stall_i` is 0. The cycle after a completion always has `mem_valid_o` at 0.
- R5: While `mem_stall_i` is 1 during an access, `mem_valid_o` stays 1, and the address and channel stay unchanged. No ack is given.
- R6: Each completed access advances that region's offset by one. Offset `2**OFF_W-1` wraps to 0.
- R7: Completing the last word of the lower field (offset `2**(OFF_W-1)-1`) sets the region's pending bit and sets its half flag to 0. Completing offset `2**OFF_W-1` sets the pending bit and sets the half flag to 1. The effect is visible in the cycle after completion.
- R8: A pending bit stays set until its clear input is high at a clock edge, and it reads 0 after that edge. If a set and a clear fall on the same edge, the set wins.
- R9: No access starts while `mem_stall_i` is 1 or while no request is present.
- R10: During a completing cycle exactly one ack bit is high, and it is the bit of the granted region. In every other cycle all ack bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_req_i | input | NUM_CH | Incoming-word request, bit k = channel k+1 |
| out_req_i | input | NUM_CH | Outgoing-word request, bit k = channel k+1 |
| mem_stall_i | input | 1 | Memory bank conflict, holds the current access |
| mem_valid_o | output | 1 | Access presented to memory |
| mem_we_o | output | 1 | 1 = write (incoming region) |
| mem_addr_o | output | ADDR_W | Word address |
| chan_o | output | CH_W | Granted channel number, 1..NUM_CH |
| in_ack_o | output | NUM_CH | Incoming word completed, one-hot |
| out_ack_o | output | NUM_CH | Outgoing word completed, one-hot |
| in_irq_clr_i | input | NUM_CH | Clear incoming pending bit |
| out_irq_clr_i | input | NUM_CH | Clear outgoing pending bit |
| in_irq_o | output | NUM_CH | Incoming field-complete pending bits |
| out_irq_o | output | NUM_CH | Outgoing field-complete pending bits |
| in_half_o | output | NUM_CH | Incoming field last completed (0 lower, 1 upper) |
| out_half_o | output | NUM_CH | Outgoing field last completed (0 lower, 1 upper) |

## Verification
A request driven before clock edge E0 is granted at E0. The address, write enable and channel number are then valid in the cycle after E0, and the ack shows up combinationally in that same cycle once the stall is low. The offset, pending bit and half flag change at the completing edge and are sampled in the following cycle, which must also show `mem_valid_o` low. The bench drives all inputs at falling edges and reads every result at the falling edge of the cycle it is due in. It checks ack values 1 ns after it changes the stall input. It runs a full ring on all thirty regions with stalls of several lengths inserted, then tests priority ordering, a stall while idle, and a set and clear that coincide.

// File: rtl/chan_ring_pkg.sv
package chan_ring_pkg;
  typedef enum logic {
    DIR_IN  = 1'b0,
    DIR_OUT = 1'b1
  } dir_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } arb_st_e;
endpackage

// File: rtl/chan_ring_arb.sv
module chan_ring_arb #(
  parameter int N     = 30,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins: scan from top so the last hit is the smallest
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/chan_ring_ptr.sv
module chan_ring_ptr #(
  parameter int OFF_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clr_i,
  output logic [OFF_W-1:0] off_o,
  output logic             pend_o,
  output logic             half_o
);
  logic field_end;

  // all low bits set: last word of whichever field is active
  assign field_end = &off_o[OFF_W-2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_o  <= '0;
      pend_o <= 1'b0;
      half_o <= 1'b0;
    end else begin
      if (step_i) off_o <= off_o + OFF_W'(1);
      if (step_i && field_end) begin
        pend_o <= 1'b1;
        half_o <= off_o[OFF_W-1];
      end else if (clr_i) begin
        pend_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/chan_ring_addr.sv
module chan_ring_addr #(
  parameter int NUM_CH    = 15,
  parameter int OFF_W     = 6,
  parameter int ADDR_W    = 18,
  parameter int BASE_ADDR = 512,
  localparam int CH_W     = $clog2(NUM_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] in_req_i,
  input  logic [NUM_CH-1:0] out_req_i,
  input  logic              mem_stall_i,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [NUM_CH-1:0] in_ack_o,
  output logic [NUM_CH-1:0] out_ack_o,
  input  logic [NUM_CH-1:0] in_irq_clr_i,
  input  logic [NUM_CH-1:0] out_irq_clr_i,
  output logic [NUM_CH-1:0] in_irq_o,
  output logic [NUM_CH-1:0] out_irq_o,
  output logic [NUM_CH-1:0] in_half_o,
  output logic [NUM_CH-1:0] out_half_o
);
  import chan_ring_pkg::*;

  localparam int NUM_REQ = 2 * NUM_CH;
  localparam int IDX_W   = $clog2(NUM_REQ);

  arb_st_e          st_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] arb_idx;
  logic             arb_any;
  logic             done;
  logic [NUM_REQ-1:0] req_all;
  logic [NUM_REQ-1:0] clr_all;
  logic [NUM_REQ-1:0] pend_all;
  logic [NUM_REQ-1:0] half_all;
  logic [NUM_REQ-1:0] ack_all;
  logic [OFF_W-1:0]   off_all [NUM_REQ];

  // requester r = 2*(channel-1) + direction
  for (genvar c = 0; c < NUM_CH; c++) begin : g_map
    assign req_all[2*c]   = in_req_i[c];
    assign req_all[2*c+1] = out_req_i[c];
    assign clr_all[2*c]   = in_irq_clr_i[c];
    assign clr_all[2*c+1] = out_irq_clr_i[c];
    assign in_irq_o[c]    = pend_all[2*c];
    assign out_irq_o[c]   = pend_all[2*c+1];
    assign in_half_o[c]   = half_all[2*c];
    assign out_half_o[c]  = half_all[2*c+1];
    assign in_ack_o[c]    = ack_all[2*c];
    assign out_ack_o[c]   = ack_all[2*c+1];
  end

  chan_ring_arb #(.N(NUM_REQ), .IDX_W(IDX_W)) u_arb (
    .req_i (req_all),
    .any_o (arb_any),
    .idx_o (arb_idx)
  );

  assign mem_valid_o = (st_q == ST_BUSY);
  assign done        = mem_valid_o && !mem_stall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (arb_any && !mem_stall_i) begin
          st_q  <= ST_BUSY;
          idx_q <= arb_idx;
        end
        ST_BUSY: if (!mem_stall_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_ptr
    assign ack_all[r] = done && (idx_q == IDX_W'(r));
    chan_ring_ptr #(.OFF_W(OFF_W)) u_ptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (ack_all[r]),
      .clr_i  (clr_all[r]),
      .off_o  (off_all[r]),
      .pend_o (pend_all[r]),
      .half_o (half_all[r])
    );
  end

  // region base is idx*2**OFF_W, so the offset fills the low bits
  assign mem_addr_o = ADDR_W'(BASE_ADDR) + ADDR_W'({idx_q, off_all[idx_q]});
  assign mem_we_o   = (idx_q[0] == DIR_IN);
  assign chan_o     = CH_W'(idx_q >> 1) + CH_W'(1);
endmodule

// File: rtl/chan_ring_chk.sv
module chan_ring_chk #(
  parameter int NUM_CH    = 15,
  parameter int OFF_W     = 6,
  parameter int ADDR_W    = 18,
  parameter int BASE_ADDR = 512,
  parameter int CH_W      = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_stall_i,
  input logic              mem_valid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [CH_W-1:0]   chan_o,
  input logic [NUM_CH-1:0] in_req_i,
  input logic [NUM_CH-1:0] out_req_i,
  input logic [NUM_CH-1:0] in_ack_o,
  input logic [NUM_CH-1:0] out_ack_o,
  input logic [NUM_CH-1:0] in_irq_o,
  input logic [NUM_CH-1:0] in_irq_clr_i
);
  localparam int SPAN = 2 * NUM_CH * (2 ** OFF_W);

  a_r4_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_stall_i) |=> !mem_valid_o);

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_stall_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(chan_o)));

  a_r9_no_grant_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_valid_o && mem_stall_i) |=> !mem_valid_o);

  a_r9_no_grant_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_valid_o && (in_req_i == '0) && (out_req_i == '0)) |=> !mem_valid_o);

  a_r10_ack_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({in_ack_o, out_ack_o}) && (((in_ack_o | out_ack_o) != '0) == (mem_valid_o && !mem_stall_i)));

  a_r2_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> ((mem_addr_o >= ADDR_W'(BASE_ADDR)) && (mem_addr_o < ADDR_W'(BASE_ADDR + SPAN))
                     && (chan_o >= CH_W'(1)) && (chan_o <= CH_W'(NUM_CH))));

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(in_irq_o) & ~$past(in_irq_clr_i)) & ~in_irq_o) == '0));
endmodule

bind chan_ring_addr chan_ring_chk #(
  .NUM_CH(NUM_CH), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .CH_W(CH_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_stall_i  (mem_stall_i),
  .mem_valid_o  (mem_valid_o),
  .mem_addr_o   (mem_addr_o),
  .chan_o       (chan_o),
  .in_req_i     (in_req_i),
  .out_req_i    (out_req_i),
  .in_ack_o     (in_ack_o),
  .out_ack_o    (out_ack_o),
  .in_irq_o     (in_irq_o),
  .in_irq_clr_i (in_irq_clr_i)
);

// File: tb/sim_chan_ring_addr.sv
`timescale 1ns/1ps
module sim_chan_ring_addr;
  localparam int NCH  = 15;
  localparam int NR   = 30;
  localparam int SZ   = 64;
  localparam int BASE = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] in_req = '0, out_req = '0, in_clr = '0, out_clr = '0;
  logic stall = 1'b0;
  logic valid, we;
  logic [17:0] addr;
  logic [3:0] chan;
  logic [NCH-1:0] in_ack, out_ack, in_irq, out_irq, in_half, out_half;

  int checks = 0, errors = 0, cycles = 0;
  int exp_off [NR];
  bit exp_pend [NR];
  bit exp_half [NR];

  always #2 clk = ~clk;

  chan_ring_addr u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_req_i(in_req), .out_req_i(out_req),
    .mem_stall_i(stall), .mem_valid_o(valid), .mem_we_o(we), .mem_addr_o(addr),
    .chan_o(chan), .in_ack_o(in_ack), .out_ack_o(out_ack),
    .in_irq_clr_i(in_clr), .out_irq_clr_i(out_clr), .in_irq_o(in_irq),
    .out_irq_o(out_irq), .in_half_o(in_half), .out_half_o(out_half)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NR-1:0] pend_vec();
    logic [NR-1:0] v;
    for (int c = 0; c < NCH; c++) begin v[2*c] = in_irq[c]; v[2*c+1] = out_irq[c]; end
    return v;
  endfunction

  function automatic logic [NR-1:0] half_vec();
    logic [NR-1:0] v;
    for (int c = 0; c < NCH; c++) begin v[2*c] = in_half[c]; v[2*c+1] = out_half[c]; end
    return v;
  endfunction

  function automatic logic [NR-1:0] ack_vec();
    logic [NR-1:0] v;
    for (int c = 0; c < NCH; c++) begin v[2*c] = in_ack[c]; v[2*c+1] = out_ack[c]; end
    return v;
  endfunction

  function automatic logic [NR-1:0] exp_pend_vec();
    logic [NR-1:0] v;
    for (int r = 0; r < NR; r++) v[r] = exp_pend[r];
    return v;
  endfunction

  task automatic set_req(input int r, input bit v);
    if (r % 2 == 0) in_req[r/2] = v; else out_req[r/2] = v;
  endtask

  task automatic set_clr(input int r, input bit v);
    if (r % 2 == 0) in_clr[r/2] = v; else out_clr[r/2] = v;
  endtask

  // check the presented access against region r
  task automatic chk_access(input int r);
    chk(valid === 1'b1, "R9 access started", valid, 1);
    chk(addr == 18'(BASE + r*SZ + exp_off[r]), "R2/R6 address", addr, BASE + r*SZ + exp_off[r]);
    chk(we == (r % 2 == 0), "R2 write enable", we, r % 2 == 0);
    chk(chan == 4'(r/2 + 1), "R3 channel", chan, r/2 + 1);
  endtask

  // model the completion of region r, optionally with a clear on the same edge
  task automatic model_step(input int r, input bit clr);
    int o = exp_off[r];
    if (o % (SZ/2) == SZ/2 - 1) begin
      exp_pend[r] = 1'b1;
      exp_half[r] = (o >= SZ/2);
    end else if (clr) exp_pend[r] = 1'b0;
    exp_off[r] = (o + 1) % SZ;
  endtask

  task automatic chk_irq();
    logic [NR-1:0] hv = half_vec();
    chk(pend_vec() == exp_pend_vec(), "R7/R8 pending vector", pend_vec(), exp_pend_vec());
    for (int r = 0; r < NR; r++)
      if (exp_pend[r]) chk(hv[r] == exp_half[r], "R7 half flag", hv[r], exp_half[r]);
  endtask

  // called at a falling edge; returns at a falling edge
  task automatic xfer(input int r, input int nstall, input bit clr);
    set_req(r, 1'b1);
    @(negedge clk);
    chk_access(r);
    set_req(r, 1'b0);
    if (nstall > 0) begin
      stall = 1'b1;
      #1;
      chk(ack_vec() == '0, "R10 no ack while stalled", ack_vec(), 0);
      for (int k = 0; k < nstall; k++) begin
        @(negedge clk);
        chk(valid === 1'b1, "R5 held valid", valid, 1);
        chk(addr == 18'(BASE + r*SZ + exp_off[r]), "R5 held address", addr, BASE + r*SZ + exp_off[r]);
        chk(ack_vec() == '0, "R5 no ack", ack_vec(), 0);
      end
      stall = 1'b0;
      #1;
    end
    chk(ack_vec() == (NR'(1) << r), "R10 ack one-hot", ack_vec(), NR'(1) << r);
    if (clr) set_clr(r, 1'b1);
    @(negedge clk);
    set_clr(r, 1'b0);
    model_step(r, clr);
    chk(valid === 1'b0, "R4 idle gap", valid, 0);
    chk_irq();
  endtask

  task automatic clear_irq(input int r);
    set_clr(r, 1'b1);
    @(negedge clk);
    set_clr(r, 1'b0);
    exp_pend[r] = 1'b0;
    chk_irq();
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [NR-1:0] pend_set;
    int order [4];
    for (int r = 0; r < NR; r++) begin exp_off[r] = 0; exp_pend[r] = 0; exp_half[r] = 0; end

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(valid === 1'b0, "R1 valid in reset", valid, 0);
    chk(pend_vec() == '0, "R1 pending in reset", pend_vec(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid === 1'b0, "R1 valid after reset", valid, 0);
    chk(ack_vec() == '0, "R1 ack after reset", ack_vec(), 0);

    // R6/R7 full ring on every region, with stalls (R5) sprinkled in
    for (int r = 0; r < NR; r++) begin
      for (int k = 0; k < SZ; k++) begin
        xfer(r, (k % 13 == 4) ? (1 + k % 3) : 0, 1'b0);
        if (k == SZ/2 - 1 && (r % 3 != 0)) clear_irq(r);
      end
      clear_irq(r);
    end

    // R8 set and clear on the same edge: set wins
    for (int k = 0; k < SZ/2 - 1; k++) xfer(3, 0, 1'b0);
    xfer(3, 0, 1'b1);
    chk(exp_pend[3] == 1'b1, "R8 set beats clear model", exp_pend[3], 1);
    repeat (2) @(negedge clk);
    chk_irq();
    clear_irq(3);

    // R9 no grant while stalled in idle
    stall = 1'b1;
    set_req(0, 1'b1);
    repeat (3) begin
      @(negedge clk);
      chk(valid === 1'b0, "R9 no grant under stall", valid, 0);
    end
    stall = 1'b0;
    @(negedge clk);
    chk_access(0);
    set_req(0, 1'b0);
    @(negedge clk);
    model_step(0, 1'b0);

    // R3 fixed priority across several pending requests
    order[0] = 4; order[1] = 5; order[2] = 8; order[3] = 17;
    set_req(8, 1'b1); set_req(17, 1'b1); set_req(5, 1'b1); set_req(4, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk_access(order[i]);
      set_req(order[i], 1'b0);
      @(negedge clk);
      chk(valid === 1'b0, "R4 gap between grants", valid, 0);
      model_step(order[i], 1'b0);
    end
    pend_set = pend_vec();
    chk(pend_set == exp_pend_vec(), "R8 pending unchanged", pend_set, exp_pend_vec());

    finish_run();
  end
endmodule